// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a clocked behavioural model of a byte-wide one-time-programmable memory for use inside a larger digital design. Each clock it decodes the operating mode from an active-low chip select, an active-low output enable and two digital flags. One flag says the programming supply is present. The other says the identifier address line is held at its high voltage. It then returns a byte with a valid flag, where a low valid flag stands for a floating bus, together with an idle (low-power) indicator.

Programming can only clear bits. Each program cycle ANDs the incoming byte into the addressed cell. A wipe input brings every cell back to all ones. A separate identifier path returns two fixed codes, each with odd parity in bit 7, so that a programmer can recognise the part.

The array depth is set by the address width (2K bytes by default, 32K at a width of 15). Supply levels and analog timing are not modelled.

Top module: `otp_eprom_model`

## Requirements
- R1: While `rst` is high the output register holds `rdata_vld`=0, `rdata`=00h and `idle`=1, and every cell is set to FFh; a read right after reset returns FFh.
- R2: With `chip_sel_n`=0, `out_en_n`=0, `prog_pwr`=0 and `id_volt`=0 sampled at a clock edge, `rdata` equals the stored byte at `addr` and `rdata_vld`=1 from that edge onward (one register of latency).
- R3: With `chip_sel_n`=1 sampled at an edge, the next outputs are `idle`=1, `rdata_vld`=0 and `rdata`=00h, whatever `out_en_n` and `prog_pwr` are.
- R4: With `chip_sel_n`=0, `out_en_n`=1 and `prog_pwr`=0, the outputs are `idle`=0, `rdata_vld`=0 and `rdata`=00h, and no cell changes.
- R5: With `prog_pwr`=1, `chip_sel_n`=0 and `out_en_n`=1, the byte on `wdata` is programmed at `addr` and the outputs show `rdata_vld`=0.
- R6: A program cycle stores the old cell value AND `wdata`, so a one programmed over a zero leaves the zero.
- R7: With `prog_pwr`=1, `chip_sel_n`=0, `out_en_n`=0 and `id_volt`=0, the stored byte at `addr` is returned with `rdata_vld`=1.
- R8: With `prog_pwr`=1, `chip_sel_n`=1 and `out_en_n`=1, nothing is programmed and the outputs show `rdata_vld`=0 and `idle`=1.
- R9: With `id_volt`=1, `chip_sel_n`=0 and `out_en_n`=0, and every address bit other than bit 0 and bit 9 low, the block returns 01h when bit 0 is 0 and 10h when bit 0 is 1, with `rdata_vld`=1, regardless of `prog_pwr` and of address bit 9.
- R10: Both identifier bytes have odd parity over all eight bits, with bit 7 as the parity bit.
- R11: In identifier mode, with any address bit other than bit 0 and bit 9 set, the block returns FFh.
- R12: A one-cycle `wipe` sets every cell to FFh, and it overrides a program cycle in the same clock.
- R13: The byte returned at an edge is the cell content from before any program or wipe that takes effect at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also wipes the array |
| chip_sel_n | input | 1 | Active-low device select |
| out_en_n | input | 1 | Active-low output enable |
| prog_pwr | input | 1 | Programming supply present |
| id_volt | input | 1 | Identifier address line at high voltage |
| wipe | input | 1 | Return all cells to FFh |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Byte to program |
| rdata | output | 8 | Returned byte, 00h when not valid |
| rdata_vld | output | 1 | Output driven; low models a floating bus |
| idle | output | 1 | Standby indicator |

## Verification
Two functions can land on the same clock edge. A wipe can coincide with a program cycle, and a wipe can coincide with a read or verify cycle. The bench drives both pairs in a single cycle. It then reads the targeted cells back and expects FFh, which shows that the wipe won. It also expects the byte returned in the colliding read cycle to be the value from before the wipe. A per-clock reference model holds the expected array and mode outcome, and it judges every output on every clock.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam int BYTE_W     = 8;
    localparam int ID_SEL_BIT = 0;
    localparam int ID_HV_BIT  = 9;

    localparam logic [6:0] MAKER_CODE7 = 7'h01;
    localparam logic [6:0] PART_CODE7  = 7'h10;

    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_OUT_OFF,
        MODE_READ,
        MODE_PROGRAM,
        MODE_VERIFY,
        MODE_INHIBIT,
        MODE_IDREAD
    } otp_mode_e;

    typedef struct packed {
        logic sel_n;
        logic oen_n;
        logic pwr;
        logic idv;
    } otp_ctl_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } otp_bus_t;

    function automatic logic [BYTE_W-1:0] with_odd_parity(input logic [6:0] code);
        return {~(^code), code};
    endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
    import otp_pkg::*;
(
    input  otp_ctl_t  ctl_i,
    output otp_mode_e mode_o,
    output logic      wr_en_o
);

    always_comb begin
        if (ctl_i.sel_n) begin
            mode_o = (ctl_i.pwr && ctl_i.oen_n) ? MODE_INHIBIT : MODE_STANDBY;
        end else if (!ctl_i.oen_n && ctl_i.idv) begin
            mode_o = MODE_IDREAD;
        end else if (ctl_i.pwr) begin
            mode_o = ctl_i.oen_n ? MODE_PROGRAM : MODE_VERIFY;
        end else begin
            mode_o = ctl_i.oen_n ? MODE_OUT_OFF : MODE_READ;
        end
    end

    assign wr_en_o = (mode_o == MODE_PROGRAM);

endmodule

// File: rtl/otp_array.sv
module otp_array
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rd_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || wipe_i) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
        end else if (wr_en_i) begin
            cells[addr_i] <= cells[addr_i] & wdata_i;
        end
    end

    assign rd_data_o = cells[addr_i];

    // R6: a program cycle never raises a bit at the same address
    a_r6_clear_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !wipe_i) |=>
            (!$stable(addr_i) || ((rd_data_o & ~$past(rd_data_o)) == '0)));

    // R12: after a wipe every address reads all ones
    a_r12_wipe_ones: assert property (@(posedge clk) disable iff (rst)
        wipe_i |=> (rd_data_o == '1));

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [BYTE_W-1:0] id_o
);

    localparam logic [ADDR_W-1:0] PASS_MASK =
        (ADDR_W'(1) << ID_SEL_BIT) | (ADDR_W'(1) << ID_HV_BIT);

    logic clean;

    assign clean = ((addr_i & ~PASS_MASK) == '0);

    always_comb begin
        if (!clean) begin
            id_o = '1;
        end else if (addr_i[ID_SEL_BIT]) begin
            id_o = with_odd_parity(PART_CODE7);
        end else begin
            id_o = with_odd_parity(MAKER_CODE7);
        end
    end

endmodule

// File: rtl/otp_eprom_model.sv
module otp_eprom_model
    import otp_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              prog_pwr,
    input  logic              id_volt,
    input  logic              wipe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rdata_vld,
    output logic              idle
);

    localparam logic [ADDR_W-1:0] ID_PASS =
        (ADDR_W'(1) << ID_SEL_BIT) | (ADDR_W'(1) << ID_HV_BIT);

    otp_ctl_t          ctl;
    otp_mode_e         mode;
    logic              wr_en;
    logic [BYTE_W-1:0] cell_q;
    logic [BYTE_W-1:0] id_byte;
    otp_bus_t          bus_d, bus_q;
    logic              idle_q;

    assign ctl = '{sel_n: chip_sel_n, oen_n: out_en_n, pwr: prog_pwr, idv: id_volt};

    otp_mode_dec u_dec (
        .ctl_i   (ctl),
        .mode_o  (mode),
        .wr_en_o (wr_en)
    );

    otp_array #(.ADDR_W(ADDR_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .wipe_i    (wipe),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rd_data_o (cell_q)
    );

    otp_id_rom #(.ADDR_W(ADDR_W)) u_id (
        .addr_i (addr),
        .id_o   (id_byte)
    );

    always_comb begin
        unique case (mode)
            MODE_READ, MODE_VERIFY: bus_d = '{vld: 1'b1, data: cell_q};
            MODE_IDREAD:            bus_d = '{vld: 1'b1, data: id_byte};
            default:                bus_d = '{vld: 1'b0, data: '0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q  <= '{vld: 1'b0, data: '0};
            idle_q <= 1'b1;
        end else begin
            bus_q  <= bus_d;
            idle_q <= chip_sel_n;
        end
    end

    assign rdata     = bus_q.data;
    assign rdata_vld = bus_q.vld;
    assign idle      = idle_q;

    // R3: deselect floats the bus and raises the standby indicator
    a_r3_standby_float: assert property (@(posedge clk) disable iff (rst)
        chip_sel_n |=> (idle && !rdata_vld && rdata == 8'h00));

    // R4: selected with output disabled keeps the bus floating
    a_r4_out_off: assert property (@(posedge clk) disable iff (rst)
        (!chip_sel_n && out_en_n) |=> (!idle && !rdata_vld));

    // R10: a clean identifier access returns an odd-parity byte
    a_r10_id_parity: assert property (@(posedge clk) disable iff (rst)
        (!chip_sel_n && !out_en_n && id_volt && ((addr & ~ID_PASS) == '0))
            |=> (rdata_vld && (^rdata)));

    // R11: a misused identifier access returns all ones
    a_r11_id_misuse: assert property (@(posedge clk) disable iff (rst)
        (!chip_sel_n && !out_en_n && id_volt && ((addr & ~ID_PASS) != '0))
            |=> (rdata_vld && rdata == 8'hFF));

endmodule

// File: tb/otp_eprom_model_test.sv
`timescale 1ns/1ps
module otp_eprom_model_test;

    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0] ID_MASK = 11'h201;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_sel_n = 1'b1;
    logic          out_en_n = 1'b1;
    logic          prog_pwr = 1'b0;
    logic          id_volt = 1'b0;
    logic          wipe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic          rdata_vld;
    logic          idle;

    always #2.5 clk = ~clk;

    otp_eprom_model #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .rst        (rst),
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .prog_pwr   (prog_pwr),
        .id_volt    (id_volt),
        .wipe       (wipe),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rdata_vld  (rdata_vld),
        .idle       (idle)
    );

    int         checks = 0;
    int         fails = 0;
    bit         done = 0;
    logic [7:0] ref_mem [DEPTH];
    logic [7:0] exp_d = 8'h00;
    logic       exp_en = 1'b0;
    logic       exp_sb = 1'b1;
    bit         exp_par = 0;
    bit         exp_valid = 0;
    string      exp_tag = "R1";
    string      tag_ovr = "";

    // reference model: evaluates the requirement table once per clock
    always @(posedge clk) begin : model
        string      t;
        logic [7:0] nd;
        logic       ne;
        nd = 8'h00;
        ne = 1'b0;
        t  = "";
        exp_par = 0;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
            exp_d  = 8'h00;
            exp_en = 1'b0;
            exp_sb = 1'b1;
            exp_tag = "R1";
        end else begin
            if (chip_sel_n) begin
                t = (prog_pwr && out_en_n) ? "R8" : "R3";
            end else if (!out_en_n && id_volt) begin
                ne = 1'b1;
                if ((addr & ~ID_MASK) == '0) begin
                    nd = addr[0] ? 8'h10 : 8'h01;
                    t = "R9";
                    exp_par = 1;
                end else begin
                    nd = 8'hFF;
                    t = "R11";
                end
            end else if (prog_pwr && out_en_n) begin
                t = "R5";
                ref_mem[addr] = ref_mem[addr] & wdata;
            end else if (prog_pwr) begin
                ne = 1'b1;
                nd = ref_mem[addr];
                t = "R7";
            end else if (out_en_n) begin
                t = "R4";
            end else begin
                ne = 1'b1;
                nd = ref_mem[addr];
                t = "R2";
            end
            if (wipe) begin
                for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
            end
            exp_d   = nd;
            exp_en  = ne;
            exp_sb  = chip_sel_n;
            exp_tag = (tag_ovr != "") ? tag_ovr : t;
        end
        exp_valid = 1;
    end

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (exp_valid && !done) begin
            chk(exp_tag, "rdata_vld", {7'b0, rdata_vld}, {7'b0, exp_en});
            chk(exp_tag, "rdata",     rdata, exp_d);
            chk(exp_tag, "idle",      {7'b0, idle}, {7'b0, exp_sb});
            if (exp_par) chk("R10", "odd parity", {7'b0, ^rdata}, 8'h01);
        end
    end

    task automatic cyc(input logic c, input logic o, input logic v, input logic h,
                       input logic e, input int a, input logic [7:0] d, input string tg);
        chip_sel_n = c;
        out_en_n   = o;
        prog_pwr   = v;
        id_volt    = h;
        wipe       = e;
        addr       = a[AW-1:0];
        wdata      = d;
        tag_ovr    = tg;
        @(negedge clk);
    endtask

    task automatic rd(input int a, input string tg);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, tg);
    endtask

    task automatic prog(input int a, input logic [7:0] d, input string tg);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, a, d, tg);
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cyc(1, 1, 0, 0, 0, 0, 8'h00, "R1");
        rd(5, "R1");
        rd(DEPTH - 1, "R1");
        // R5 / R2: program then read
        prog(5, 8'hA5, "R5");
        rd(5, "R2");
        // R6: clear-only programming
        prog(5, 8'h0F, "R6");
        cyc(0, 0, 1, 0, 0, 5, 8'h00, "R7");
        prog(5, 8'hFF, "R6");
        rd(5, "R6");
        // spread of addresses and patterns
        for (int i = 0; i < 24; i++) prog((i * 83 + 17) % DEPTH, 8'((i * 29) ^ 8'h5A), "");
        for (int i = 0; i < 24; i++) rd((i * 83 + 17) % DEPTH, "");
        // R4: output disabled, no write
        cyc(0, 1, 0, 0, 0, 6, 8'h00, "R4");
        rd(6, "R4");
        // R8: inhibited, no write
        cyc(1, 1, 1, 0, 0, 7, 8'h00, "R8");
        rd(7, "R8");
        // R3: standby with output enable low and with supply on
        cyc(1, 0, 0, 0, 0, 5, 8'h00, "R3");
        cyc(1, 0, 1, 1, 0, 5, 8'h00, "R3");
        // R9 / R10: identifier bytes
        cyc(0, 0, 0, 1, 0, 11'h000, 8'h00, "R9");
        cyc(0, 0, 0, 1, 0, 11'h001, 8'h00, "R9");
        cyc(0, 0, 0, 1, 0, 11'h201, 8'h00, "R9");
        cyc(0, 0, 1, 1, 0, 11'h200, 8'h00, "R9");
        // R11: misuse
        cyc(0, 0, 0, 1, 0, 11'h008, 8'h00, "R11");
        cyc(0, 0, 0, 1, 0, 11'h401, 8'h00, "R11");
        // R13: read in the wipe cycle shows old byte; R12 afterwards
        prog(9, 8'h3C, "R5");
        rd(5, "R2");
        cyc(0, 0, 0, 0, 1, 5, 8'h00, "R13");
        rd(5, "R12");
        rd(9, "R12");
        // R12: wipe overrides program in the same cycle
        cyc(0, 1, 1, 0, 1, 9, 8'h00, "R12");
        rd(9, "R12");
        // R13: verify in the wipe cycle after reprogramming
        prog(12, 8'h81, "R5");
        cyc(0, 0, 1, 0, 1, 12, 8'h00, "R13");
        rd(12, "R12");
        prog(12, 8'h7E, "R5");
        rd(12, "R2");
        cyc(1, 1, 0, 0, 0, 0, 8'h00, "");
        finish_run();
    end

    initial begin
        #(100000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule